// File: doc/BRIEF.md
# Binary64 Compare Unit with Condition Flags

This unit orders two IEEE-754 binary64 values, or one value against positive zero, and reports the outcome as a four-bit condition code. Bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V. It also raises an invalid-operation flag when the compare meets a NaN under the rules below. The unit takes one request per cycle. The result is registered, so it appears one cycle after the request, together with a one-cycle valid pulse.

Two control inputs select the variant. `signal_mode` selects the signalling compare, which treats every NaN as an invalid operation. `vs_zero` discards `op_b` and compares `op_a` against +0.0. The unit handles only packed operands. Subnormal values are not normalised: their raw encodings already order correctly.

The code is generic over exponent and fraction widths. The default widths give the 64-bit format.

Top module: `f64_compare_flags`

## Requirements
- R1: An operand whose exponent field is all ones and whose fraction is nonzero is a NaN. If either compared operand is a NaN, the code is unordered: `nzcv` = 4'b0011 (C and V set).
- R2: In quiet mode (`signal_mode`=0), `invalid` is set only when a NaN operand has its most significant fraction bit clear (signalling NaN). A quiet NaN (that bit set) does not set `invalid`, and neither does any non-NaN operand in either mode.
- R3: In signalling mode (`signal_mode`=1), any NaN operand, quiet or signalling, sets `invalid`.
- R4: Operands that are bit-for-bit identical and not NaN compare equal, and so do two zeros of any sign. Equal gives `nzcv` = 4'b0110 (Z and C set).
- R5: When the sign bits (bit 63) differ and the values are not both zero, the negative operand is the lesser. A negative `op_a` gives less-than, `nzcv` = 4'b1000. A positive `op_a` gives greater-than, `nzcv` = 4'b0010.
- R6: When the signs match, the magnitudes (bits 62:0) are compared as unsigned integers. The ordering is reversed when both operands are negative.
- R7: With `vs_zero`=1, `op_b` has no effect: the second operand is +0.0, in both quiet and signalling modes.
- R8: Both operands are tested for NaN independently. A signalling NaN in either position, or any NaN in signalling mode, sets `invalid`.
- R9: A request accepted on a rising edge with `in_valid`=1 puts its result on `nzcv` and `invalid` at that edge. `out_valid` is high for exactly that one following cycle.
- R10: Reset clears `out_valid`, `nzcv` and `invalid`. While `in_valid` is low, `nzcv` and `invalid` keep their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 64 | First operand (binary64) |
| op_b | input | 64 | Second operand (binary64) |
| signal_mode | input | 1 | 1 = signalling compare, 0 = quiet compare |
| vs_zero | input | 1 | 1 = compare op_a with +0.0 |
| out_valid | output | 1 | Result valid pulse |
| nzcv | output | 4 | Condition code {N,Z,C,V} |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The hardest cases to reach from the ports are the exponent and fraction values at the edges of their ranges. Examples are a NaN with only the lowest fraction bit set, a negative zero against a positive zero, and equal magnitudes with opposite signs. With 64-bit operands these are a vanishing fraction of the input space. The bench therefore builds a second instance with a 3-bit exponent and a 2-bit fraction. It applies every operand pair in every mode combination, so each of those encodings appears as a matter of course. Directed 64-bit cases then confirm that the default widths behave the same.

// File: rtl/f64cmp_pkg.sv
package f64cmp_pkg;

  typedef enum logic [1:0] {
    ORD_LESS    = 2'd0,
    ORD_EQUAL   = 2'd1,
    ORD_GREATER = 2'd2,
    ORD_UNORD   = 2'd3
  } cmp_order_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  // condition code for each ordering
  function automatic logic [3:0] order_to_nzcv(cmp_order_e ord);
    logic [3:0] f;
    f = '0;
    case (ord)
      ORD_LESS:    f[FLAG_N] = 1'b1;
      ORD_EQUAL:   begin f[FLAG_Z] = 1'b1; f[FLAG_C] = 1'b1; end
      ORD_GREATER: f[FLAG_C] = 1'b1;
      default:     begin f[FLAG_C] = 1'b1; f[FLAG_V] = 1'b1; end
    endcase
    return f;
  endfunction

  // one operand's contribution to the invalid flag
  function automatic logic nan_raises_invalid(logic nan, logic quiet, logic sig_mode);
    return nan & (sig_mode | ~quiet);
  endfunction

endpackage

// File: rtl/f64cmp_operand.sv
module f64cmp_operand #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] word,
  output logic         sign,
  output logic [W-2:0] mag,
  output logic         is_nan,
  output logic         is_quiet,
  output logic         is_zero
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f    = word[W-2 -: EXP_W];
  assign frac_f   = word[FRAC_W-1:0];
  assign sign     = word[W-1];
  assign mag      = word[W-2:0];
  assign is_nan   = (&exp_f) & (|frac_f);
  assign is_quiet = frac_f[FRAC_W-1];
  assign is_zero  = ~(|mag);
endmodule

// File: rtl/f64cmp_order.sv
module f64cmp_order
  import f64cmp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  logic             sign_a,
  input  logic             sign_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  input  logic             zero_a,
  input  logic             zero_b,
  input  logic             any_nan,
  output cmp_order_e       order,
  output logic             raw_equal,
  output logic             mag_below
);
  logic both_zero;

  assign raw_equal = (sign_a == sign_b) && (mag_a == mag_b);
  assign both_zero = zero_a & zero_b;
  assign mag_below = mag_a < mag_b;

  always_comb begin
    if (any_nan)
      order = ORD_UNORD;
    else if (raw_equal || both_zero)
      order = ORD_EQUAL;
    else if (sign_a != sign_b)
      order = sign_a ? ORD_LESS : ORD_GREATER;
    else
      order = (sign_a ^ mag_below) ? ORD_LESS : ORD_GREATER;
  end
endmodule

// File: rtl/f64cmp_flags.sv
module f64cmp_flags
  import f64cmp_pkg::*;
#(
  parameter int N_OPS = 2
) (
  input  cmp_order_e       order,
  input  logic [N_OPS-1:0] nan,
  input  logic [N_OPS-1:0] quiet,
  input  logic             signal_mode,
  output logic [3:0]       nzcv,
  output logic             invalid
);
  logic [N_OPS-1:0] inv_per_op;

  for (genvar i = 0; i < N_OPS; i++) begin : g_inv
    assign inv_per_op[i] = nan_raises_invalid(nan[i], quiet[i], signal_mode);
  end

  assign nzcv    = order_to_nzcv(order);
  assign invalid = |inv_per_op;
endmodule

// File: rtl/f64_compare_flags.sv
module f64_compare_flags
  import f64cmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         signal_mode,
  input  logic         vs_zero,
  output logic         out_valid,
  output logic [3:0]   nzcv,
  output logic         invalid
);
  localparam int N_OPS = 2;
  localparam int MAG_W = W - 1;

  logic [W-1:0]     opnd [N_OPS];
  logic [N_OPS-1:0] sign_w;
  logic [MAG_W-1:0] mag_w [N_OPS];
  logic [N_OPS-1:0] nan_w;
  logic [N_OPS-1:0] quiet_w;
  logic [N_OPS-1:0] zero_w;
  cmp_order_e       order_w;
  logic             raw_equal_w;
  logic             mag_below_w;
  logic [3:0]       nzcv_next;
  logic             invalid_next;

  // second operand is replaced by +0.0 in the zero variant
  assign opnd[0] = op_a;
  assign opnd[1] = vs_zero ? '0 : op_b;

  for (genvar i = 0; i < N_OPS; i++) begin : g_op
    f64cmp_operand #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word    (opnd[i]),
      .sign    (sign_w[i]),
      .mag     (mag_w[i]),
      .is_nan  (nan_w[i]),
      .is_quiet(quiet_w[i]),
      .is_zero (zero_w[i])
    );
  end

  f64cmp_order #(.MAG_W(MAG_W)) u_order (
    .sign_a   (sign_w[0]),
    .sign_b   (sign_w[1]),
    .mag_a    (mag_w[0]),
    .mag_b    (mag_w[1]),
    .zero_a   (zero_w[0]),
    .zero_b   (zero_w[1]),
    .any_nan  (|nan_w),
    .order    (order_w),
    .raw_equal(raw_equal_w),
    .mag_below(mag_below_w)
  );

  f64cmp_flags #(.N_OPS(N_OPS)) u_flags (
    .order      (order_w),
    .nan        (nan_w),
    .quiet      (quiet_w),
    .signal_mode(signal_mode),
    .nzcv       (nzcv_next),
    .invalid    (invalid_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      nzcv      <= 4'b0000;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        nzcv    <= nzcv_next;
        invalid <= invalid_next;
      end
    end
  end
endmodule

// File: rtl/f64_compare_flags_chk.sv
module f64_compare_flags_chk
  import f64cmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         signal_mode,
  input logic         vs_zero,
  input logic         out_valid,
  input logic [3:0]   nzcv,
  input logic         invalid,
  input cmp_order_e   order_w,
  input logic [1:0]   nan_w
);
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(nzcv) && $stable(invalid)));

  p_nan_unordered_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (|nan_w)) |=> (nzcv == 4'b0011));

  p_signal_any_nan_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && signal_mode && (|nan_w)) |=> invalid);

  p_number_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(|nan_w)) |=> !invalid);

  p_zero_operand_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vs_zero) |-> !nan_w[1]);

  p_identical_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !vs_zero && (op_a == op_b) && !nan_w[0]) |=> (nzcv == 4'b0110));

  p_code_matches_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (nzcv == order_to_nzcv($past(order_w))));

  p_legal_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (nzcv == 4'b1000 || nzcv == 4'b0110 ||
                   nzcv == 4'b0010 || nzcv == 4'b0011));
endmodule

bind f64_compare_flags f64_compare_flags_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .op_a       (op_a),
  .op_b       (op_b),
  .signal_mode(signal_mode),
  .vs_zero    (vs_zero),
  .out_valid  (out_valid),
  .nzcv       (nzcv),
  .invalid    (invalid),
  .order_w    (order_w),
  .nan_w      (nan_w)
);

// File: tb/f64_compare_flags_test.sv
`timescale 1ns/1ps
module f64_compare_flags_test;
  localparam int SE = 3;
  localparam int SF = 2;
  localparam int SW = 1 + SE + SF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        iv64 = 0, sm64 = 0, vz64 = 0;
  logic [63:0] a64 = '0, b64 = '0;
  logic        ov64, inv64;
  logic [3:0]  nz64;

  logic          ivs = 0, sms = 0, vzs = 0;
  logic [SW-1:0] as_ = '0, bs_ = '0;
  logic          ovs, invs;
  logic [3:0]    nzs;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  f64_compare_flags uut (
    .clk(clk), .rst_n(rst_n), .in_valid(iv64), .op_a(a64), .op_b(b64),
    .signal_mode(sm64), .vs_zero(vz64), .out_valid(ov64), .nzcv(nz64), .invalid(inv64));

  f64_compare_flags #(.EXP_W(SE), .FRAC_W(SF)) uut_mini (
    .clk(clk), .rst_n(rst_n), .in_valid(ivs), .op_a(as_), .op_b(bs_),
    .signal_mode(sms), .vs_zero(vzs), .out_valid(ovs), .nzcv(nzs), .invalid(invs));

  // reference: ordering through signed keys, result {nzcv, invalid}
  function automatic logic [4:0] model(longint unsigned a, longint unsigned b,
                                       int ew, int fw, bit sm, bit vz);
    longint unsigned emask, fmask, mmask, bu;
    bit na, nb, qa, qb, inv;
    longint ka, kb;
    logic [3:0] f;
    int tot;
    tot   = 1 + ew + fw;
    emask = (64'd1 << ew) - 1;
    fmask = (64'd1 << fw) - 1;
    mmask = (64'd1 << (tot - 1)) - 1;
    bu    = vz ? 64'd0 : b;
    na = (((a >> fw) & emask) == emask) && ((a & fmask) != 0);
    nb = (((bu >> fw) & emask) == emask) && ((bu & fmask) != 0);
    qa = ((a >> (fw - 1)) & 1) != 0;
    qb = ((bu >> (fw - 1)) & 1) != 0;
    inv = (na && (sm || !qa)) || (nb && (sm || !qb));
    ka = longint'(a & mmask);  if (((a >> (tot - 1)) & 1) != 0)  ka = -ka;
    kb = longint'(bu & mmask); if (((bu >> (tot - 1)) & 1) != 0) kb = -kb;
    if (na || nb)    f = 4'b0011;
    else if (ka < kb) f = 4'b1000;
    else if (ka == kb) f = 4'b0110;
    else f = 4'b0010;
    return {f, inv};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run64(logic [63:0] a, logic [63:0] b, bit sm, bit vz,
                       logic [4:0] exp, string tag);
    @(negedge clk);
    a64 = a; b64 = b; sm64 = sm; vz64 = vz; iv64 = 1'b1;
    @(negedge clk);
    iv64 = 1'b0;
    check(tag, {59'd0, nz64, inv64}, {59'd0, exp});
    check({tag, " model"}, {59'd0, exp}, {59'd0, model(a, b, 11, 52, sm, vz)});
  endtask

  task automatic run_small(logic [SW-1:0] a, logic [SW-1:0] b, bit sm, bit vz);
    logic [4:0] exp;
    string tag;
    longint ka, kb;
    @(negedge clk);
    as_ = a; bs_ = b; sms = sm; vzs = vz; ivs = 1'b1;
    @(negedge clk);
    ivs = 1'b0;
    exp = model(a, b, SE, SF, sm, vz);
    ka = a[SW-2:0]; kb = vz ? 0 : b[SW-2:0];
    if (exp[4:1] == 4'b0011) tag = sm ? "R3" : "R1";
    else if (vz) tag = "R7";
    else if (exp[4:1] == 4'b0110) tag = "R4";
    else if (a[SW-1] != b[SW-1]) tag = "R5";
    else tag = "R6";
    if (ka < 0 || kb < 0) tag = "R6";
    check(tag, {59'd0, nzs, invs}, {59'd0, exp});
  endtask

  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] MONE = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] MTWO = 64'hC000_0000_0000_0000;
  localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] TINY = 64'h0000_0000_0000_0001;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !done) begin
      bad++;
      total++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check("R10 reset", {59'd0, ov64, nz64, inv64}, 64'd0);
    check("R10 reset mini", {59'd0, ovs, nzs, invs}, 64'd0);
    rst_n = 1'b1;

    // R9: one-cycle valid pulse
    @(negedge clk);
    a64 = ONE; b64 = TWO; sm64 = 0; vz64 = 0; iv64 = 1'b1;
    @(negedge clk);
    iv64 = 1'b0;
    check("R9 pulse high", {63'd0, ov64}, 64'd1);
    check("R6 1<2", {60'd0, nz64}, 64'h8);
    @(negedge clk);
    check("R9 pulse low", {63'd0, ov64}, 64'd0);
    // R10: hold while idle, inputs changing
    a64 = TWO; b64 = ONE;
    @(negedge clk);
    check("R10 hold", {59'd0, nz64, inv64}, {59'd0, 4'b1000, 1'b0});

    run64(TWO,  ONE,  0, 0, 5'b0010_0, "R6 2>1");
    run64(MONE, MTWO, 0, 0, 5'b0010_0, "R6 -1>-2");
    run64(MTWO, MONE, 0, 0, 5'b1000_0, "R6 -2<-1");
    run64(MONE, ONE,  0, 0, 5'b1000_0, "R5 -1<1");
    run64(ONE,  MONE, 0, 0, 5'b0010_0, "R5 1>-1");
    run64(PZ,   NZ,   0, 0, 5'b0110_0, "R4 +0=-0");
    run64(TINY, TINY, 1, 0, 5'b0110_0, "R4 identical");
    run64(PINF, ONE,  1, 0, 5'b0010_0, "R2 inf no invalid");
    run64(QNAN, ONE,  0, 0, 5'b0011_0, "R1 R2 qnan quiet");
    run64(SNAN, ONE,  0, 0, 5'b0011_1, "R2 snan quiet");
    run64(QNAN, ONE,  1, 0, 5'b0011_1, "R3 qnan signalling");
    run64(ONE,  SNAN, 0, 0, 5'b0011_1, "R8 snan second");
    run64(ONE,  QNAN, 1, 0, 5'b0011_1, "R8 qnan second signalling");
    run64(MONE, QNAN, 1, 1, 5'b1000_0, "R7 op_b ignored");
    run64(NZ,   SNAN, 0, 1, 5'b0110_0, "R7 -0 vs zero");
    run64(TINY, ONE,  0, 1, 5'b0010_0, "R7 tiny vs zero");

    // exhaustive sweep of the reduced format (R1..R8)
    for (int a = 0; a < (1 << SW); a++)
      for (int b = 0; b < (1 << SW); b++)
        for (int m = 0; m < 4; m++)
          run_small(SW'(a), SW'(b), m[0], m[1]);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule